// File: doc/BRIEF.md
# Virtual Output Queue Crossbar Scheduler

This block computes the crossbar configuration for an N-by-N input-queued switch in which each input holds one logical queue per output. Every input presents one request bit per output, set while that queue holds at least one cell. On each timeslot strobe the scheduler runs several request-grant-accept rounds in a single clock cycle and builds a one-to-one input/output pairing. It registers that pairing as a grant matrix and raises a one-cycle dequeue strobe for each queue it selected.

In each round, every still-free output offers a grant to one requesting free input. It picks that input by round-robin, starting from its own grant pointer. Every input that received grants accepts one of them by round-robin, starting from its own accept pointer. Later rounds only consider pairs whose input and output are both still free. The pointers move to one past the chosen index, and only for pairings made in the first round. This lets pairings rotate over time without starving any queue. The default round count equals N, so the result is always maximal. Requests are kept per output, so a cell waiting for a contended output never holds back a cell at the same input that is bound for an idle one.

Top module: `voq_sched`

## Requirements
- R1: After reset `valid_o` and `grant_o` are zero and every grant and accept pointer is zero. As a result, an all-ones request matrix on the first timeslot is paired as the identity (input k to output k).
- R2: In every published matrix each input row has at most one bit set and each output column has at most one bit set.
- R3: A grant bit is set only where the request bit sampled on the timeslot strobe was set. Bit `i*N+j` of `req_i`, `grant_o` and `deq_o` refers to input i and output j.
- R4: The pairing is maximal. No pair with a set request may have both its input and its output left unpaired.
- R5: The matrix and `valid_o` are registered on the clock edge where `slot_i` is high. `valid_o` is high for exactly the following cycle. `grant_o` holds its value until the next strobe.
- R6: `deq_o` equals `grant_o` in the cycle `valid_o` is high and is zero in every other cycle.
- R7: Among the inputs requesting it, an output grants the first one at or after its grant pointer, in increasing index order with wrap-around. An input accepts the first offering output at or after its accept pointer in the same order.
- R8: A pairing made in the first round sets that output's grant pointer to the input index plus one and that input's accept pointer to the output index plus one, both modulo N. Pairings made in later rounds leave all pointers unchanged.
- R9: An input whose request to one output loses contention is still paired with another free output it requests in the same timeslot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Timeslot strobe: compute and register a new pairing |
| req_i | input | N*N | Queue non-empty flags, bit i*N+j is input i to output j |
| grant_o | output | N*N | Registered crossbar configuration, same bit layout |
| valid_o | output | 1 | High for one cycle after each timeslot strobe |
| deq_o | output | N*N | Dequeue strobe for each selected queue |

## Verification
The pointer rule for later rounds is the hardest part to observe at the ports. A pointer wrongly moved by a second-round pairing leaves no trace until a later timeslot routes a grant through it. So the bench applies an all-ones matrix twice after reset. The second pairing (0 to 1, 1 to 0, then 2 to 2, 3 to 3) comes out this way only if the later rounds of the first slot left the pointers untouched. A single hot output driven for five slots shows the grant pointer walking across all inputs and wrapping. A pre-conditioned pointer state sets up contention in which an input loses its first choice yet must still be paired elsewhere.

// File: rtl/voq_pkg.sv
package voq_pkg;
  // index one past v, wrapping at n
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
  parameter int N  = 4,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o
);
  always_comb begin
    logic found;
    int   idx;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_i) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/voq_rga_stage.sv
module voq_rga_stage #(
  parameter int N  = 4,
  parameter int PW = $clog2(N)
) (
  input  logic [N*N-1:0]  req_i,
  input  logic [N*N-1:0]  taken_i,
  input  logic [N*PW-1:0] gptr_i,
  input  logic [N*PW-1:0] aptr_i,
  output logic [N*N-1:0]  acc_o
);
  logic [N-1:0] in_busy, out_busy;
  logic [N-1:0] col_req [N];
  logic [N-1:0] col_gnt [N];
  logic [N-1:0] row_gnt [N];
  logic [N-1:0] row_acc [N];
  logic [N-1:0] row_tak [N];
  logic [N-1:0] col_tak [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign row_tak[i][j] = taken_i[i*N+j];
      assign col_tak[j][i] = taken_i[i*N+j];
      assign col_req[j][i] = req_i[i*N+j] & ~in_busy[i] & ~out_busy[j];
      assign row_gnt[i][j] = col_gnt[j][i];
      assign acc_o[i*N+j]  = row_acc[i][j];
    end
    assign in_busy[i]  = |row_tak[i];
    assign out_busy[i] = |col_tak[i];
  end

  // grant phase: one arbiter per output
  for (genvar j = 0; j < N; j++) begin : g_out
    voq_rr_pick #(.N(N), .PW(PW)) u_gnt (
      .req_i (col_req[j]),
      .ptr_i (gptr_i[j*PW +: PW]),
      .gnt_o (col_gnt[j])
    );
  end

  // accept phase: one arbiter per input
  for (genvar i = 0; i < N; i++) begin : g_in
    voq_rr_pick #(.N(N), .PW(PW)) u_acc (
      .req_i (row_gnt[i]),
      .ptr_i (aptr_i[i*PW +: PW]),
      .gnt_o (row_acc[i])
    );
  end
endmodule

// File: rtl/voq_sched.sv
module voq_sched #(
  parameter int N     = 4,
  parameter int ITERS = N
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           slot_i,
  input  logic [N*N-1:0] req_i,
  output logic [N*N-1:0] grant_o,
  output logic           valid_o,
  output logic [N*N-1:0] deq_o
);
  localparam int PW = $clog2(N);
  localparam int NN = N * N;

  logic [PW-1:0]   gptr_q [N];
  logic [PW-1:0]   aptr_q [N];
  logic [N*PW-1:0] gptr_flat, aptr_flat;
  logic [NN-1:0]   cum [ITERS+1];
  logic [NN-1:0]   acc [ITERS];
  logic [NN-1:0]   grant_q;
  logic            valid_q;

  for (genvar k = 0; k < N; k++) begin : g_flat
    assign gptr_flat[k*PW +: PW] = gptr_q[k];
    assign aptr_flat[k*PW +: PW] = aptr_q[k];
  end

  assign cum[0] = '0;
  for (genvar s = 0; s < ITERS; s++) begin : g_iter
    voq_rga_stage #(.N(N), .PW(PW)) u_stage (
      .req_i   (req_i),
      .taken_i (cum[s]),
      .gptr_i  (gptr_flat),
      .aptr_i  (aptr_flat),
      .acc_o   (acc[s])
    );
    assign cum[s+1] = cum[s] | acc[s];
  end

  // pointers follow first-round pairings only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) begin
        gptr_q[k] <= '0;
        aptr_q[k] <= '0;
      end
    end else if (slot_i) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (acc[0][i*N+j]) begin
            gptr_q[j] <= PW'(voq_pkg::wrap_inc(i, N));
            aptr_q[i] <= PW'(voq_pkg::wrap_inc(j, N));
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= slot_i;
      if (slot_i) grant_q <= cum[ITERS];
    end
  end

  assign grant_o = grant_q;
  assign valid_o = valid_q;
  assign deq_o   = valid_q ? grant_q : '0;
endmodule

// File: rtl/voq_sched_chk.sv
module voq_sched_chk #(
  parameter int N = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           slot_i,
  input logic [N*N-1:0] req_i,
  input logic [N*N-1:0] grant_o,
  input logic           valid_o
);
  logic [N*N-1:0] req_q;
  logic [N-1:0]   row_g [N];
  logic [N-1:0]   col_g [N];
  logic [N-1:0]   in_used, out_used;
  logic           gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= '0;
    else if (slot_i) req_q <= req_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_r
    for (genvar j = 0; j < N; j++) begin : g_c
      assign row_g[i][j] = grant_o[i*N+j];
      assign col_g[j][i] = grant_o[i*N+j];
    end
    assign in_used[i]  = |row_g[i];
    assign out_used[i] = |col_g[i];

    AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $onehot0(row_g[i])); // R2
    AST_COL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $onehot0(col_g[i])); // R2
  end

  always_comb begin
    gap = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (req_q[i*N+j] && !in_used[i] && !out_used[j]) gap = 1'b1;
  end

  AST_GRANT_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((grant_o & ~req_q) == '0)); // R3
  AST_MAXIMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !gap); // R4
  AST_VALID_AFTER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> valid_o); // R5
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !valid_o); // R5
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable(grant_o)); // R5
endmodule

bind voq_sched voq_sched_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .slot_i  (slot_i),
  .req_i   (req_i),
  .grant_o (grant_o),
  .valid_o (valid_o)
);

// File: tb/voq_sched_tb_top.sv
`timescale 1ns/1ps
module voq_sched_tb_top;
  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          slot_i = 1'b0;
  logic [NN-1:0] req_i = '0;
  logic [NN-1:0] grant_o, deq_o;
  logic          valid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  voq_sched #(.N(N)) dut_i (
    .clk_i, .rst_ni, .slot_i, .req_i, .grant_o, .valid_o, .deq_o
  );

  task automatic chk(input bit ok, input string tag, input logic [NN-1:0] act,
                     input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; slot_i = 1'b0; req_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // drive one strobe; return after the registered result is visible
  task automatic do_slot(input logic [NN-1:0] r);
    @(negedge clk_i);
    req_i = r; slot_i = 1'b1;
    @(negedge clk_i);
    slot_i = 1'b0;
    chk(valid_o === 1'b1, "R5 valid after slot", NN'(valid_o), NN'(1));
    chk(deq_o === grant_o, "R6 deq during valid", deq_o, grant_o);
  endtask

  function automatic bit pairing_ok(input logic [NN-1:0] r, input logic [NN-1:0] g);
    int rc, cc;
    logic [N-1:0] iu, ou;
    iu = '0; ou = '0;
    for (int i = 0; i < N; i++) begin
      rc = 0; cc = 0;
      for (int j = 0; j < N; j++) begin
        rc += int'(g[i*N+j]); cc += int'(g[j*N+i]);
        if (g[i*N+j]) begin iu[i] = 1'b1; ou[j] = 1'b1; end
        if (g[i*N+j] && !r[i*N+j]) return 1'b0;
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (r[i*N+j] && !iu[i] && !ou[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic t_reset();
    do_reset();
    chk(valid_o === 1'b0, "R1 valid after reset", NN'(valid_o), '0);
    chk(grant_o === '0, "R1 grant after reset", grant_o, '0);
    chk(deq_o === '0, "R6 deq idle after reset", deq_o, '0);
  endtask

  task automatic t_full_twice();
    do_reset();
    do_slot('1);
    chk(grant_o === 16'h8421, "R1 identity from zero pointers", grant_o, 16'h8421);
    do_slot('1);
    chk(grant_o === 16'h8412, "R8 later rounds keep pointers", grant_o, 16'h8412);
  endtask

  task automatic t_hot_output();
    logic [NN-1:0] exp;
    do_reset();
    for (int s = 0; s < 5; s++) begin
      do_slot(16'h1111);
      exp = '0; exp[(s % N)*N] = 1'b1;
      chk(grant_o === exp, "R7 grant pointer rotation", grant_o, exp);
    end
  endtask

  task automatic t_hol();
    do_reset();
    do_slot(16'h0001);
    chk(grant_o === 16'h0001, "R8 single pairing", grant_o, 16'h0001);
    do_slot(16'h0015);
    chk(grant_o === 16'h0014, "R9 loser served on free output", grant_o, 16'h0014);
  endtask

  task automatic t_hold_and_idle();
    logic [NN-1:0] held;
    do_reset();
    do_slot(16'h0240);
    held = grant_o;
    chk(pairing_ok(16'h0240, held), "R4 sparse pairing", held, 16'h0240);
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R5 valid one cycle", NN'(valid_o), '0);
    chk(grant_o === held, "R5 grant held", grant_o, held);
    chk(deq_o === '0, "R6 deq idle", deq_o, '0);
    do_slot('0);
    chk(grant_o === '0, "R3 no request no grant", grant_o, '0);
  endtask

  task automatic t_random();
    logic [NN-1:0] r;
    do_reset();
    for (int s = 0; s < 60; s++) begin
      r = NN'($urandom);
      do_slot(r);
      chk(pairing_ok(r, grant_o), "R2 R3 R4 random pairing", grant_o, r);
    end
  endtask

  initial begin
    t_reset();
    t_full_twice();
    t_hot_output();
    t_hol();
    t_hold_and_idle();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule